// File: doc/BRIEF.md
# Programmable-Logic Register Bank with Shared Clear, Set, Power-Up Hold and Test Load

This block holds the D flip-flops behind the output cells of a small sum-of-products logic device, together with the control they share. All registers take their D inputs from the logic array on each rising clock edge. Two shared product terms override that capture. One clears every register at once, without waiting for a clock. The other sets every register at the next rising edge.

After power becomes good, a cycle counter holds every register at 0 for a fixed number of edges before normal capture starts. A diagnostic load mode, reduced here to a digital level, writes each register from the value seen on its pin. Once the mode is left, the loaded state can be read back.

Each register's value is returned as feedback to the array. Its inverse goes to the pin driver, so a cleared register shows as a high pin whatever polarity the array applies in front of the D input.

Top module: `palreg_bank`

## Requirements
- R1: While `async_clr_pt` is 1, every bit of `q_fb` is 0 without waiting for a clock edge.
- R2: While `async_clr_pt` is 1, neither set, test load nor capture changes `q_fb` at a clock edge.
- R3: With `async_clr_pt` at 0, no hold, and `load_mode` at 0, a rising edge with `sync_set_pt` at 1 makes every bit of `q_fb` 1, whatever `d` is.
- R4: With no clear, hold, set or load active, each rising edge copies `d` into `q_fb`.
- R5: `pin_out` is always the bitwise inverse of `q_fb`, so a cleared register gives a pin value of 8'hFF.
- R6: After `rst` falls with `pwr_good` at 1, the first PWRUP_CYCLES (default 16) rising edges force `q_fb` to 0. Capture of `d` starts at edge PWRUP_CYCLES+1.
- R7: A rising edge with `pwr_good` at 0 clears `q_fb`. When `pwr_good` returns to 1, the hold of R6 restarts from the first edge.
- R8: With `async_clr_pt` at 0 and no hold, a rising edge with `load_mode` at 1 writes `load_data` into `q_fb`. This takes priority over `sync_set_pt` and `d`.
- R9: Once `load_mode` returns to 0, the loaded value stays on `q_fb`, and its inverse on `pin_out`, until the next rising edge.
- R10: A rising edge with the synchronous `rst` at 1 clears `q_fb`. This takes priority over test load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge active |
| rst | input | 1 | Synchronous active-high block reset; also restarts the power-up hold |
| pwr_good | input | 1 | Power-good level; 0 means supply not yet valid |
| async_clr_pt | input | 1 | Shared clear product term, asynchronous, active high |
| sync_set_pt | input | 1 | Shared set product term, applied at the clock edge, active high |
| load_mode | input | 1 | Diagnostic test-load mode level |
| load_data | input | NREG | Values seen on the pins, loaded while in test-load mode |
| d | input | NREG | D inputs from the logic array |
| q_fb | output | NREG | Register values fed back to the array |
| pin_out | output | NREG | Inverted register values toward the pin drivers |

## Verification
The clocked properties assume that `async_clr_pt` is never raised and dropped again between two rising edges. A pulse like that would clear the registers without the clock-sampled term showing it. The stimulus therefore changes every input only on the falling edge and keeps the clear term high across at least one rising edge. The properties also assume that `rst` is held from time zero. The bench starts with it asserted for several cycles before any other activity.

// File: rtl/palreg_pkg.sv
package palreg_pkg;

    // Synchronous action taken by every register at a rising edge
    typedef enum logic [1:0] {
        ACT_CAPTURE = 2'd0,
        ACT_SET     = 2'd1,
        ACT_LOAD    = 2'd2,
        ACT_CLEAR   = 2'd3
    } reg_act_e;

    // Synchronous requests feeding the priority decode
    typedef struct packed {
        logic rst;
        logic hold;
        logic load;
        logic set;
    } sync_req_t;

    // Clear beats test load, test load beats set, set beats capture
    function automatic reg_act_e pick_action(sync_req_t r);
        reg_act_e a;
        if (r.rst || r.hold)
            a = ACT_CLEAR;
        else if (r.load)
            a = ACT_LOAD;
        else if (r.set)
            a = ACT_SET;
        else
            a = ACT_CAPTURE;
        return a;
    endfunction

endpackage

// File: rtl/palreg_pwrup_timer.sv
module palreg_pwrup_timer #(
    parameter int PWRUP_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good,
    output logic hold
);
    localparam int CNT_W = $clog2(PWRUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PWRUP_CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwr_good)
            cnt <= '0;
        else if (cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    assign hold = (cnt != CNT_MAX) || !pwr_good;
endmodule

// File: rtl/palreg_ctrl.sv
module palreg_ctrl
    import palreg_pkg::*;
(
    input  logic     rst,
    input  logic     hold,
    input  logic     load_mode,
    input  logic     sync_set_pt,
    output reg_act_e act
);
    sync_req_t req;

    always_comb begin
        req.rst  = rst;
        req.hold = hold;
        req.load = load_mode;
        req.set  = sync_set_pt;
        act      = pick_action(req);
    end
endmodule

// File: rtl/palreg_cell.sv
module palreg_cell
    import palreg_pkg::*;
(
    input  logic     clk,
    input  logic     aclr,
    input  reg_act_e act,
    input  logic     d,
    input  logic     ld,
    output logic     q
);
    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) begin
            q <= 1'b0;
        end else begin
            unique case (act)
                ACT_CLEAR:   q <= 1'b0;
                ACT_LOAD:    q <= ld;
                ACT_SET:     q <= 1'b1;
                ACT_CAPTURE: q <= d;
                default:     q <= d;
            endcase
        end
    end
endmodule

// File: rtl/palreg_bank.sv
module palreg_bank
    import palreg_pkg::*;
#(
    parameter int NREG         = 8,
    parameter int PWRUP_CYCLES = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwr_good,
    input  logic            async_clr_pt,
    input  logic            sync_set_pt,
    input  logic            load_mode,
    input  logic [NREG-1:0] load_data,
    input  logic [NREG-1:0] d,
    output logic [NREG-1:0] q_fb,
    output logic [NREG-1:0] pin_out
);
    logic     pwr_hold;
    reg_act_e act;

    palreg_pwrup_timer #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .pwr_good (pwr_good),
        .hold     (pwr_hold)
    );

    palreg_ctrl u_ctrl (
        .rst         (rst),
        .hold        (pwr_hold),
        .load_mode   (load_mode),
        .sync_set_pt (sync_set_pt),
        .act         (act)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_cell
        palreg_cell u_cell (
            .clk  (clk),
            .aclr (async_clr_pt),
            .act  (act),
            .d    (d[i]),
            .ld   (load_data[i]),
            .q    (q_fb[i])
        );
    end

    // Pin driver path is inverting
    assign pin_out = ~q_fb;
endmodule

// File: rtl/palreg_bank_chk.sv
module palreg_bank_chk #(
    parameter int NREG = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            hold,
    input logic            async_clr_pt,
    input logic            sync_set_pt,
    input logic            load_mode,
    input logic [NREG-1:0] load_data,
    input logic [NREG-1:0] d,
    input logic [NREG-1:0] q_fb,
    input logic [NREG-1:0] pin_out
);
    // R1 / R2: clear term forces zero at every sampled edge
    a_r1_async_zero: assert property (@(posedge clk) disable iff (rst)
        async_clr_pt |-> (q_fb == '0));

    // R3: set beats capture
    a_r3_set_all: assert property (@(posedge clk) disable iff (rst)
        (sync_set_pt && !load_mode && !async_clr_pt && !hold)
        |=> (async_clr_pt || q_fb == '1));

    // R4: plain capture
    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
        (!sync_set_pt && !load_mode && !async_clr_pt && !hold)
        |=> (async_clr_pt || q_fb == $past(d)));

    // R5: inverted pin path
    a_r5_pin_inv: assert property (@(posedge clk) disable iff (rst)
        pin_out == ~q_fb);

    // R6 / R7: hold keeps the bank clear
    a_r6_hold_zero: assert property (@(posedge clk) disable iff (rst)
        hold |=> (q_fb == '0 || (!hold && !$past(hold))));

    // R8: test load beats set and capture
    a_r8_load: assert property (@(posedge clk) disable iff (rst)
        (load_mode && !async_clr_pt && !hold)
        |=> (async_clr_pt || q_fb == $past(load_data)));
endmodule

bind palreg_bank palreg_bank_chk #(.NREG(NREG)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hold         (pwr_hold),
    .async_clr_pt (async_clr_pt),
    .sync_set_pt  (sync_set_pt),
    .load_mode    (load_mode),
    .load_data    (load_data),
    .d            (d),
    .q_fb         (q_fb),
    .pin_out      (pin_out)
);

// File: tb/tb_palreg_bank.sv
module tb_palreg_bank;
    localparam int N  = 8;
    localparam int PW = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         pwr_good;
    logic         async_clr_pt;
    logic         sync_set_pt;
    logic         load_mode;
    logic [N-1:0] load_data;
    logic [N-1:0] d;
    logic [N-1:0] q_fb;
    logic [N-1:0] pin_out;

    int  n_chk  = 0;
    int  n_err  = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    palreg_bank #(.NREG(N), .PWRUP_CYCLES(PW)) dut (
        .clk          (clk),
        .rst          (rst),
        .pwr_good     (pwr_good),
        .async_clr_pt (async_clr_pt),
        .sync_set_pt  (sync_set_pt),
        .load_mode    (load_mode),
        .load_data    (load_data),
        .d            (d),
        .q_fb         (q_fb),
        .pin_out      (pin_out)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // Hold window: PW edges read zero, edge PW+1 captures value v
    task automatic check_hold(input string req, input logic [N-1:0] v);
        d = v;
        for (int k = 1; k <= PW; k++) begin
            @(negedge clk);
            chk(req, q_fb, '0);
        end
        @(negedge clk);
        chk(req, q_fb, v);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; pwr_good = 1'b1; async_clr_pt = 1'b0; sync_set_pt = 1'b0;
        load_mode = 1'b0; load_data = '0; d = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset q", q_fb, '0);
        chk("R5 reset pin", pin_out, 8'hFF);

        // R6: power-up hold boundary after reset release
        rst = 1'b0;
        check_hold("R6", 8'hA5);

        // R4 / R5 exhaustive capture sweep
        for (int v = 0; v < 256; v++) begin
            d = N'(v);
            @(negedge clk);
            chk("R4", q_fb, N'(v));
            chk("R5", pin_out, ~N'(v));
        end

        // R3: set beats d = 0
        d = '0; sync_set_pt = 1'b1;
        @(negedge clk);
        chk("R3", q_fb, 8'hFF);
        chk("R5 set pin", pin_out, 8'h00);

        // R1: clear is immediate
        async_clr_pt = 1'b1;
        #1;
        chk("R1", q_fb, '0);
        @(negedge clk);
        chk("R2 over set", q_fb, '0);
        load_mode = 1'b1; load_data = 8'h3C; d = 8'h99;
        @(negedge clk);
        chk("R2 over load", q_fb, '0);
        async_clr_pt = 1'b0; load_mode = 1'b0; sync_set_pt = 1'b0;
        @(negedge clk);
        chk("R4 after clear", q_fb, 8'h99);

        // R8: load sweep with set and d competing
        load_mode = 1'b1; sync_set_pt = 1'b1; d = 8'h00;
        for (int v = 0; v < 256; v++) begin
            load_data = N'(v);
            @(negedge clk);
            chk("R8", q_fb, N'(v));
        end

        // R9: readback after leaving load mode
        load_data = 8'hC3;
        @(negedge clk);
        load_mode = 1'b0; sync_set_pt = 1'b0; d = 8'h11;
        #1;
        chk("R9 q", q_fb, 8'hC3);
        chk("R9 pin", pin_out, 8'h3C);
        @(negedge clk);
        chk("R4 after readback", q_fb, 8'h11);

        // R10: reset beats load
        load_mode = 1'b1; load_data = 8'hF0; rst = 1'b1;
        @(negedge clk);
        chk("R10", q_fb, '0);
        rst = 1'b0; load_mode = 1'b0;
        check_hold("R6 after R10", 8'h6B);

        // R7: power loss clears and restarts the hold
        d = 8'h77;
        @(negedge clk);
        chk("R4 pre R7", q_fb, 8'h77);
        pwr_good = 1'b0;
        @(negedge clk);
        chk("R7 clear", q_fb, '0);
        @(negedge clk);
        chk("R7 low", q_fb, '0);
        pwr_good = 1'b1;
        check_hold("R7 restart", 8'h77);

        finish_run();
    end
endmodule